// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block sequences the two gate-enable outputs of a synchronous half-bridge: one for the high-side switch and one for the low-side switch. It takes a three-level switching command as a 2-bit code, a run enable, and an active-low request for zero-current mode. From these it decides which switch may conduct. Before it raises either gate, it waits until the opposite gate reports that it is off, and then counts a fixed non-overlap interval.

In the low phase, zero-current mode can end conduction early. A comparator flag reports that the inductor current has reached zero. The block ignores this flag for a blanking interval after the low-side gate rises. Once the flag is seen, the low-side gate stays off until the low phase ends. Three conditions force both gates off: supply-good low, the power-up calibration window, and an over-temperature trip. The over-temperature lockout holds until a separate cool-down flag is seen. A build parameter removes this lockout. All analog sensing is presented as digital inputs.

The gate sequencer state machine has these states:

- `ST_IDLE`: both gates off.
- `ST_WAIT_HI` / `ST_WAIT_LO`: waiting for off-feedback and counting the non-overlap interval.
- `ST_HI_ON`: high-side gate on.
- `ST_LO_BLANK`: low-side gate on, zero-cross flag masked.
- `ST_LO_ON`: low-side gate on, zero-cross flag watched.
- `ST_LO_CUT`: low-side gate cut for the rest of the low phase.

Its transitions are:

- **Any state → `ST_IDLE`** when the run permission drops.
- **Command to a side → that side's wait state**, from any state that is not already on or heading to that side.
- **Wait → on**, when the count completes.
- **Blank → on or cut**, at the end of blanking.
- **On → cut**, when the zero-cross flag is seen in zero-current mode.
- **Any on, wait or cut state → `ST_IDLE`**, on an all-off command.

The power qualifier has three states:

- `PQ_DOWN`: supply is bad.
- `PQ_CAL`: calibration window is running.
- `PQ_READY`: calibration is done.

Its transitions are:

- **`PQ_DOWN` → `PQ_CAL`** when supply-good is sampled high.
- **`PQ_CAL` → `PQ_READY`** when the calibration count completes.
- **Any state → `PQ_DOWN`** when supply-good is sampled low.

Top module: `hb_gate_seq`

## Requirements
- R1: When `enable_i` is sampled low, both gate outputs are low after that clock edge, whatever the command and zero-current inputs are.
- R2: The command code selects the target gate. Code 2'b10 targets the high-side gate only. Code 2'b00 targets the low-side gate only. Codes 2'b01 and 2'b11 turn both gates off.
- R3: When the opposite off-feedback stays asserted, a gate rises after the DEAD_CYC+1-th clock edge, counting the edge that first samples the new command. It makes no difference whether the other gate was on or both were off.
- R4: A gate never rises while the opposite off-feedback is low. After that feedback is released, the gate rises on the DEAD_CYC-th consecutive edge that samples it high.
- R5: A command change during a non-overlap wait cancels the pending turn-on. The new target is then timed from the edge that samples the change. The two gate outputs are never high in the same cycle.
- R6: When `zcd_en_n_i` is 1, the low-side gate stays on for the whole low phase, whatever the zero-cross flag does.
- R7: When `zcd_en_n_i` is 0, the zero-cross flag has no effect on the first BLANK_CYC-1 edges after the low-side gate rises. If the flag is held high from the rise, the low-side gate stays high for exactly BLANK_CYC cycles.
- R8: Once cut by the zero-cross flag, the low-side gate stays low for the rest of that low phase, even if the flag drops. The next low phase turns it on again with the normal R3 timing.
- R9: A gate can first rise no earlier than CAL_CYC+DEAD_CYC+2 edges after the first edge that samples supply-good high; with command 2'b10 held, the high-side gate rises exactly then. When supply-good is sampled low, both gates go low after that edge, and the calibration window starts again.
- R10: When OT_PROT=1, `ot_trip_i` sampled high forces both gates low after that edge. They stay low until `ot_clear_i` is sampled high while the trip flag is low. The gate then rises DEAD_CYC+2 edges after the edge that sampled the clear.
- R11: When OT_PROT=0, the trip and clear inputs have no effect on the gates.
- R12: Synchronous reset (`rst_n` low at an edge) drives both gates low and restarts the calibration window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable_i | input | 1 | Run enable |
| pwm_code_i | input | 2 | Command: 00 low-side, 01/11 off, 10 high-side |
| zcd_en_n_i | input | 1 | Zero-current mode request, active low |
| supply_ok_i | input | 1 | Supply above lockout threshold |
| zero_cross_i | input | 1 | Inductor current reached zero |
| ot_trip_i | input | 1 | Temperature above trip point |
| ot_clear_i | input | 1 | Temperature fell below release point |
| hs_off_fb_i | input | 1 | High-side gate reported off |
| ls_off_fb_i | input | 1 | Low-side gate reported off |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable |

## Verification
The steady-state check sweeps all four command codes against both enable levels and both zero-current settings. This separates the mapping of the unused code from the true off code, and shows that enable and zero-current mode cannot override one another.

A second sweep steps through every ordered pair of command codes. It samples the outputs one cycle before and at the expected non-overlap deadline. This tells a correct dead time apart from one that is off by one, and a direct handover from one that passes through an extra idle cycle.

Directed sequences cover the following cases:

- holding off-feedback low;
- cancelling a pending turn-on;
- a zero-cross pulse inside the blanking window versus a flag held high;
- supply loss, over-temperature and reset at mid-run.

Each of these sequences measures the recovery latency against the closed-form counts in the requirements.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_HI,
        ST_HI_ON,
        ST_WAIT_LO,
        ST_LO_BLANK,
        ST_LO_ON,
        ST_LO_CUT
    } hbs_state_e;

    typedef enum logic [1:0] {
        PQ_DOWN,
        PQ_CAL,
        PQ_READY
    } hbs_pq_e;

    typedef enum logic [1:0] {
        TGT_OFF,
        TGT_HI,
        TGT_LO
    } hbs_tgt_e;

endpackage

// File: rtl/hbs_cmd_dec.sv
module hbs_cmd_dec
    import hbs_pkg::*;
(
    input  logic [1:0] pwm_code_i,
    output hbs_tgt_e   tgt_o
);

    always_comb begin
        unique case (pwm_code_i)
            2'b10:   tgt_o = TGT_HI;
            2'b00:   tgt_o = TGT_LO;
            default: tgt_o = TGT_OFF;
        endcase
    end

endmodule

// File: rtl/hbs_pwr_qual.sv
module hbs_pwr_qual
    import hbs_pkg::*;
#(
    parameter int CAL_CYC = 7000000,
    parameter bit OT_PROT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic enable_i,
    input  logic ot_trip_i,
    input  logic ot_clear_i,
    output logic run_ok_o
);

    localparam int             CW       = $clog2(CAL_CYC + 1);
    localparam logic [CW-1:0]  CAL_LAST = CW'(CAL_CYC - 1);

    hbs_pq_e         pq_q, pq_d;
    logic [CW-1:0]   cal_q, cal_d;
    logic            hot_blk;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pq_q  <= PQ_DOWN;
            cal_q <= '0;
        end else begin
            pq_q  <= pq_d;
            cal_q <= cal_d;
        end
    end

    always_comb begin
        pq_d  = pq_q;
        cal_d = cal_q;
        if (!supply_ok_i) begin
            pq_d  = PQ_DOWN;
            cal_d = '0;
        end else begin
            unique case (pq_q)
                PQ_DOWN: begin
                    pq_d  = PQ_CAL;
                    cal_d = '0;
                end
                PQ_CAL: begin
                    if (cal_q == CAL_LAST) pq_d = PQ_READY;
                    else                   cal_d = cal_q + 1'b1;
                end
                PQ_READY: pq_d = PQ_READY;
                default:  pq_d = PQ_DOWN;
            endcase
        end
    end

    generate
        if (OT_PROT) begin : g_ot
            logic hot_q;
            always_ff @(posedge clk) begin
                if (!rst_n)                       hot_q <= 1'b0;
                else if (ot_trip_i)               hot_q <= 1'b1;
                else if (ot_clear_i)              hot_q <= 1'b0;
            end
            assign hot_blk = hot_q | ot_trip_i;
        end else begin : g_no_ot
            logic ot_unused;
            assign ot_unused = ot_trip_i ^ ot_clear_i;
            assign hot_blk   = 1'b0;
        end
    endgenerate

    assign run_ok_o = (pq_q == PQ_READY) && enable_i && supply_ok_i && !hot_blk;

endmodule

// File: rtl/hbs_seq.sv
module hbs_seq
    import hbs_pkg::*;
#(
    parameter int DEAD_CYC  = 4,
    parameter int BLANK_CYC = 33
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run_ok_i,
    input  hbs_tgt_e tgt_i,
    input  logic     zcd_on_i,
    input  logic     zero_cross_i,
    input  logic     hs_off_fb_i,
    input  logic     ls_off_fb_i,
    output logic     hs_gate_o,
    output logic     ls_gate_o
);

    localparam int            MAXC       = (DEAD_CYC > BLANK_CYC) ? DEAD_CYC : BLANK_CYC;
    localparam int            CW         = $clog2(MAXC + 1);
    localparam logic [CW-1:0] DEAD_LAST  = CW'(DEAD_CYC - 1);
    localparam logic [CW-1:0] BLANK_LAST = CW'(BLANK_CYC - 1);

    hbs_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    hbs_state_e    redirect;

    always_comb begin
        unique case (tgt_i)
            TGT_HI:  redirect = ST_WAIT_HI;
            TGT_LO:  redirect = ST_WAIT_LO;
            default: redirect = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!run_ok_i) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_d  = redirect;
                    cnt_d = '0;
                end
                ST_WAIT_HI: begin
                    if (tgt_i != TGT_HI) begin
                        st_d  = redirect;
                        cnt_d = '0;
                    end else if (!ls_off_fb_i) begin
                        cnt_d = '0;
                    end else if (cnt_q == DEAD_LAST) begin
                        st_d  = ST_HI_ON;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_HI_ON: begin
                    if (tgt_i != TGT_HI) begin
                        st_d  = redirect;
                        cnt_d = '0;
                    end
                end
                ST_WAIT_LO: begin
                    if (tgt_i != TGT_LO) begin
                        st_d  = redirect;
                        cnt_d = '0;
                    end else if (!hs_off_fb_i) begin
                        cnt_d = '0;
                    end else if (cnt_q == DEAD_LAST) begin
                        st_d  = ST_LO_BLANK;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_LO_BLANK: begin
                    if (tgt_i != TGT_LO) begin
                        st_d  = redirect;
                        cnt_d = '0;
                    end else if (cnt_q == BLANK_LAST) begin
                        st_d  = (zcd_on_i && zero_cross_i) ? ST_LO_CUT : ST_LO_ON;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_LO_ON: begin
                    if (tgt_i != TGT_LO) begin
                        st_d  = redirect;
                        cnt_d = '0;
                    end else if (zcd_on_i && zero_cross_i) begin
                        st_d  = ST_LO_CUT;
                    end
                end
                ST_LO_CUT: begin
                    if (tgt_i != TGT_LO) begin
                        st_d  = redirect;
                        cnt_d = '0;
                    end
                end
                default: begin
                    st_d  = ST_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    always_comb begin
        hs_gate_o = (st_q == ST_HI_ON);
        ls_gate_o = (st_q == ST_LO_BLANK) || (st_q == ST_LO_ON);
    end

endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
    import hbs_pkg::*;
#(
    parameter int DEAD_CYC  = 4,
    parameter int BLANK_CYC = 33,
    parameter int CAL_CYC   = 7000000,
    parameter bit OT_PROT   = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_i,
    input  logic [1:0] pwm_code_i,
    input  logic       zcd_en_n_i,
    input  logic       supply_ok_i,
    input  logic       zero_cross_i,
    input  logic       ot_trip_i,
    input  logic       ot_clear_i,
    input  logic       hs_off_fb_i,
    input  logic       ls_off_fb_i,
    output logic       hs_gate_o,
    output logic       ls_gate_o
);

    hbs_tgt_e tgt;
    logic     run_ok;

    hbs_cmd_dec u_dec (
        .pwm_code_i (pwm_code_i),
        .tgt_o      (tgt)
    );

    hbs_pwr_qual #(
        .CAL_CYC (CAL_CYC),
        .OT_PROT (OT_PROT)
    ) u_pq (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok_i (supply_ok_i),
        .enable_i    (enable_i),
        .ot_trip_i   (ot_trip_i),
        .ot_clear_i  (ot_clear_i),
        .run_ok_o    (run_ok)
    );

    hbs_seq #(
        .DEAD_CYC  (DEAD_CYC),
        .BLANK_CYC (BLANK_CYC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_ok_i     (run_ok),
        .tgt_i        (tgt),
        .zcd_on_i     (!zcd_en_n_i),
        .zero_cross_i (zero_cross_i),
        .hs_off_fb_i  (hs_off_fb_i),
        .ls_off_fb_i  (ls_off_fb_i),
        .hs_gate_o    (hs_gate_o),
        .ls_gate_o    (ls_gate_o)
    );

endmodule

// File: rtl/hbs_chk.sv
module hbs_chk #(
    parameter bit OT_PROT = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       enable_i,
    input logic [1:0] pwm_code_i,
    input logic       supply_ok_i,
    input logic       ot_trip_i,
    input logic       hs_off_fb_i,
    input logic       ls_off_fb_i,
    input logic       hs_gate_o,
    input logic       ls_gate_o
);

    // R5
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate_o && ls_gate_o));

    // R1
    enable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!hs_gate_o && !ls_gate_o));

    // R4
    hs_fb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate_o) |-> $past(ls_off_fb_i));

    // R4
    ls_fb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate_o) |-> $past(hs_off_fb_i));

    // R2
    hs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_gate_o |-> $past(pwm_code_i == 2'b10));

    // R2
    ls_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ls_gate_o |-> $past(pwm_code_i == 2'b00));

    // R9
    supply_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |=> (!hs_gate_o && !ls_gate_o));

    generate
        if (OT_PROT) begin : g_ot_chk
            // R10
            ot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ot_trip_i |=> (!hs_gate_o && !ls_gate_o));
        end
    endgenerate

endmodule

bind hb_gate_seq hbs_chk #(.OT_PROT(OT_PROT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_i    (enable_i),
    .pwm_code_i  (pwm_code_i),
    .supply_ok_i (supply_ok_i),
    .ot_trip_i   (ot_trip_i),
    .hs_off_fb_i (hs_off_fb_i),
    .ls_off_fb_i (ls_off_fb_i),
    .hs_gate_o   (hs_gate_o),
    .ls_gate_o   (ls_gate_o)
);

// File: tb/hb_gate_seq_tb.sv
module hb_gate_seq_tb;

    localparam int DEAD  = 3;
    localparam int BLANK = 5;
    localparam int CAL   = 20;
    localparam int SETTLE = DEAD + BLANK + 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b1;
    logic [1:0] pwm = 2'b01;
    logic       zcd_n = 1'b1;
    logic       supply = 1'b1;
    logic       zc = 1'b0;
    logic       ot_trip = 1'b0;
    logic       ot_clear = 1'b0;
    logic       hold_ls_fb = 1'b0;
    logic       hold_hs_fb = 1'b0;
    logic       hs, ls, hs_nt, ls_nt;
    logic       hs_fb, ls_fb, hs_fb_nt, ls_fb_nt;

    int vecs = 0;
    int errs = 0;
    int ovl  = 0;

    always #2 clk = ~clk;

    assign hs_fb    = hold_hs_fb ? 1'b0 : !hs;
    assign ls_fb    = hold_ls_fb ? 1'b0 : !ls;
    assign hs_fb_nt = !hs_nt;
    assign ls_fb_nt = !ls_nt;

    hb_gate_seq #(.DEAD_CYC(DEAD), .BLANK_CYC(BLANK), .CAL_CYC(CAL), .OT_PROT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable_i(enable), .pwm_code_i(pwm),
        .zcd_en_n_i(zcd_n), .supply_ok_i(supply), .zero_cross_i(zc),
        .ot_trip_i(ot_trip), .ot_clear_i(ot_clear),
        .hs_off_fb_i(hs_fb), .ls_off_fb_i(ls_fb),
        .hs_gate_o(hs), .ls_gate_o(ls)
    );

    hb_gate_seq #(.DEAD_CYC(DEAD), .BLANK_CYC(BLANK), .CAL_CYC(CAL), .OT_PROT(1'b0)) u_dut_nt (
        .clk(clk), .rst_n(rst_n), .enable_i(enable), .pwm_code_i(pwm),
        .zcd_en_n_i(zcd_n), .supply_ok_i(supply), .zero_cross_i(zc),
        .ot_trip_i(ot_trip), .ot_clear_i(ot_clear),
        .hs_off_fb_i(hs_fb_nt), .ls_off_fb_i(ls_fb_nt),
        .hs_gate_o(hs_nt), .ls_gate_o(ls_nt)
    );

    task automatic tick();
        @(posedge clk);
        #1;
        if (hs === 1'b1 && ls === 1'b1) ovl++;
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_gate(input bit want_hs, output int n);
        n = 0;
        do begin
            tick();
            n++;
        end while (((want_hs ? hs : ls) !== 1'b1) && n < 1000);
    endtask

    function automatic int cls(input logic [1:0] c);
        return (c == 2'b10) ? 1 : ((c == 2'b00) ? 2 : 0);
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        vecs++;
        errs++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        int n;
        int k;
        bit hs_seen;
        tick_n(3);
        // R12 reset state
        chk("R12 reset hs", int'(hs), 0);
        chk("R12 reset ls", int'(ls), 0);
        pwm   = 2'b10;
        rst_n = 1'b1;
        wait_gate(1'b1, n);
        // R9 calibration latency from first edge sampling supply
        chk("R9 power-up latency", n, CAL + DEAD + 2);

        // R2 / R1 steady-state sweep
        for (int en = 0; en < 2; en++) begin
            for (int zn = 0; zn < 2; zn++) begin
                for (int c = 0; c < 4; c++) begin
                    enable = en[0];
                    zcd_n  = zn[0];
                    pwm    = c[1:0];
                    tick_n(SETTLE);
                    chk("R2/R1 steady hs", int'(hs), (en == 1 && cls(c[1:0]) == 1) ? 1 : 0);
                    chk("R2/R1 steady ls", int'(ls), (en == 1 && cls(c[1:0]) == 2) ? 1 : 0);
                end
            end
        end
        enable = 1'b1;
        zcd_n  = 1'b1;

        // R3 all ordered command pairs
        for (int f = 0; f < 4; f++) begin
            for (int t = 0; t < 4; t++) begin
                pwm = f[1:0];
                tick_n(SETTLE);
                pwm = t[1:0];
                tick_n(DEAD);
                chk("R3 pre-deadline hs", int'(hs), (cls(f[1:0]) == 1 && cls(t[1:0]) == 1) ? 1 : 0);
                chk("R3 pre-deadline ls", int'(ls), (cls(f[1:0]) == 2 && cls(t[1:0]) == 2) ? 1 : 0);
                tick();
                chk("R3 deadline hs", int'(hs), (cls(t[1:0]) == 1) ? 1 : 0);
                chk("R3 deadline ls", int'(ls), (cls(t[1:0]) == 2) ? 1 : 0);
            end
        end

        // R1 enable drop while conducting
        pwm = 2'b10;
        tick_n(SETTLE);
        enable = 1'b0;
        tick();
        chk("R1 enable drop hs", int'(hs), 0);
        enable = 1'b1;

        // R4 feedback held low blocks turn-on
        pwm = 2'b01;
        tick_n(SETTLE);
        hold_ls_fb = 1'b1;
        pwm = 2'b10;
        tick_n(12);
        chk("R4 blocked hs", int'(hs), 0);
        hold_ls_fb = 1'b0;
        wait_gate(1'b1, n);
        chk("R4 latency after release", n, DEAD);
        pwm = 2'b10;
        tick_n(SETTLE);
        hold_hs_fb = 1'b1;
        pwm = 2'b00;
        tick_n(12);
        chk("R4 blocked ls", int'(ls), 0);
        hold_hs_fb = 1'b0;
        wait_gate(1'b0, n);
        chk("R4 latency after release ls", n, DEAD);

        // R5 cancel during wait
        pwm = 2'b01;
        tick_n(SETTLE);
        pwm = 2'b10;
        tick_n(2);
        pwm = 2'b00;
        hs_seen = 1'b0;
        n = 0;
        do begin
            tick();
            n++;
            if (hs === 1'b1) hs_seen = 1'b1;
        end while (ls !== 1'b1 && n < 1000);
        chk("R5 retimed latency", n, DEAD + 1);
        chk("R5 cancelled hs", int'(hs_seen), 0);

        // R6 zero-current mode off
        zcd_n = 1'b1;
        zc    = 1'b1;
        tick_n(30);
        chk("R6 ls held", int'(ls), 1);
        zc = 1'b0;

        // R7 blanking ignores early flag
        zcd_n = 1'b0;
        pwm = 2'b10;
        tick_n(SETTLE);
        pwm = 2'b00;
        wait_gate(1'b0, n);
        chk("R7 rise latency", n, DEAD + 1);
        zc = 1'b1;
        tick_n(BLANK - 1);
        zc = 1'b0;
        tick_n(3);
        chk("R7 early flag ignored", int'(ls), 1);

        // R7 flag held from rise
        pwm = 2'b10;
        tick_n(SETTLE);
        pwm = 2'b00;
        wait_gate(1'b0, n);
        zc = 1'b1;
        k = 0;
        while (ls === 1'b1 && k < 100) begin
            tick();
            k++;
        end
        chk("R7 on-time with flag", k, BLANK);

        // R8 stays cut for the phase, next phase restarts
        zc = 1'b0;
        tick_n(6);
        chk("R8 stays cut", int'(ls), 0);
        pwm = 2'b10;
        tick_n(SETTLE);
        pwm = 2'b00;
        wait_gate(1'b0, n);
        chk("R8 next phase latency", n, DEAD + 1);
        tick_n(BLANK + 4);
        chk("R8 next phase held", int'(ls), 1);
        zcd_n = 1'b1;

        // R10 / R11 over-temperature
        pwm = 2'b10;
        tick_n(SETTLE);
        ot_trip = 1'b1;
        tick();
        ot_trip = 1'b0;
        chk("R10 trip hs", int'(hs), 0);
        chk("R11 no-protect hs", int'(hs_nt), 1);
        tick_n(6);
        chk("R10 latched hs", int'(hs), 0);
        ot_clear = 1'b1;
        tick();
        ot_clear = 1'b0;
        tick_n(DEAD);
        chk("R10 pre-resume hs", int'(hs), 0);
        tick();
        chk("R10 resume hs", int'(hs), 1);
        chk("R11 clear no effect", int'(hs_nt), 1);

        // R9 supply loss and recalibration
        supply = 1'b0;
        tick();
        chk("R9 supply loss hs", int'(hs), 0);
        tick_n(3);
        supply = 1'b1;
        wait_gate(1'b1, n);
        chk("R9 recal latency", n, CAL + DEAD + 2);

        // R12 mid-run reset
        rst_n = 1'b0;
        tick();
        chk("R12 mid reset hs", int'(hs), 0);
        tick_n(2);
        rst_n = 1'b1;
        wait_gate(1'b1, n);
        chk("R12 recal latency", n, CAL + DEAD + 2);

        // R5 overlap over whole run
        chk("R5 overlap cycles", ovl, 0);
        finish_run();
    end

endmodule